// File: doc/BRIEF.md
# Power-Good Reset Timer with Margin Freeze

This block decides when a group of sequenced supply rails may be declared good and holds the downstream system in reset until then. For each rail it receives two digital comparator results from the analog front end. One reports that the rail output is above the rising power-good level (92.5 % of the rail input). The other reports that it is above the falling level, 0.5 % lower. A per-rail hysteresis latch turns these into a clean "rail good" state. Rails that are not in use are excluded from the decision.

Once every used rail is good, the global enable flag is set and every rail undervoltage flag is set, a counter runs for a timeout. The timeout is a fixed base (200 µs worth of clock cycles by default) plus a programmed number of extra steps. Only at the end of that timeout does the active-high power-good output rise. Losing any qualifying condition clears the counter and drops power-good.

An active-low margin input lets a system deliberately move its supplies outside their normal window for test. The margin input passes through a two-flop synchronizer and a glitch filter. While the filtered margin is asserted, all monitoring is suspended: the power-good output, the rail states and the counter are frozen, and a status output reports that monitoring is off. Monitoring resumes once margin is released. A margin input left high (floating) means normal operation.

Top module: `pwrgood_reset`

## Requirements
- R1: While reset is asserted and right after its release, `pwr_good` is 0 and `mon_off` is 0.
- R2: With `en_ok` high, all `rail_uv_ok` bits high and monitoring on, `pwr_good` rises exactly at the (L+1)-th rising clock edge, where L = BASE_CYC + tmo_sel × UNIT_CYC. The first of those edges is the one that first samples the last used rail's rise and fall flags high.
- R3: A rail that is good stays good while its fall flag is high, even if its rise flag goes low. It becomes not good on the edge that samples its fall flag low. It becomes good again only when its rise flag is sampled high.
- R4: A rail whose `rail_used` bit is 0 always counts as good, whatever its comparator flags show.
- R5: If any used rail is lost before the timeout ends, the count restarts from zero. After the rail recovers, a full L+1 edges are needed, counted from the edge that samples it good again.
- R6: When `en_ok` is low or any `rail_uv_ok` bit is low (used or not), `pwr_good` is 0 after the next edge and the count is cleared. If the rails stay good and these flags return high, `pwr_good` rises on the L-th edge after their return.
- R7: With `pwr_good` high, a used rail whose fall flag goes low drops `pwr_good` on the second edge after the flag is first sampled low.
- R8: While monitoring is off, `pwr_good`, the rail states and the count do not change, whatever the rail, enable and undervoltage inputs do. This holds whether `pwr_good` is frozen at 1 or at 0.
- R9: A low pulse on `margin_n` lasting fewer than GLITCH_CYC clock cycles leaves `mon_off` at 0 and `pwr_good` unaffected.
- R10: `margin_n` driven low before edge 1 and held sets `mon_off` to 1 at edge GLITCH_CYC+2 and not before. Releasing it clears `mon_off` after the same latency.
- R11: Once `mon_off` returns to 0, the present input conditions take effect from the next edge. A supply lost during margin drops `pwr_good` one edge after `mon_off` clears. A supply gained during margin starts a new count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| margin_n | input | 1 | Active-low margin request, asynchronous, floats high |
| en_ok | input | 1 | Global enable above its threshold |
| rail_uv_ok | input | NRAIL | Per-rail input undervoltage flag, 1 = input above its lockout level |
| rail_used | input | NRAIL | 1 = rail takes part in the power-good decision |
| rail_hi_rise | input | NRAIL | Rail output above the rising power-good level |
| rail_hi_fall | input | NRAIL | Rail output above the falling power-good level |
| tmo_sel | input | TSEL_W | Number of UNIT_CYC steps added to the base timeout |
| pwr_good | output | 1 | Active-high power-good / reset release |
| mon_off | output | 1 | Monitoring suspended by margin |

## Verification
A corrupted count would show at the ports as a power-good edge that comes early or late against L+1 cycles. The bench therefore times every rise to the exact edge, for two timeout selections and after restarts. A rail latch stuck in the wrong state would show within two edges as power-good dropping or failing to drop, which the hysteresis and rail-loss checks detect. A wrong margin synchronizer or filter depth would show as `mon_off` moving one cycle off its GLITCH_CYC+2 latency, or as a short pulse getting through. A leak in the freeze would show as power-good changing while `mon_off` is high.

// File: rtl/pwrgood_pkg.sv
package pwrgood_pkg;

  // Total qualification window in cycles: base plus selected extra steps.
  function automatic int unsigned pg_limit(input int unsigned base,
                                           input int unsigned unit,
                                           input int unsigned sel);
    return base + unit * sel;
  endfunction

  // Counter width able to reach the largest selectable window.
  function automatic int unsigned pg_cnt_width(input int unsigned base,
                                               input int unsigned unit,
                                               input int unsigned sel_w);
    int unsigned top_val;
    top_val = base + unit * ((32'd1 << sel_w) - 1);
    return $clog2(top_val + 1);
  endfunction

  // Width of the glitch-filter run counter.
  function automatic int unsigned run_width(input int unsigned depth);
    return (depth < 2) ? 1 : $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/pwrgood_margin_filt.sv
module pwrgood_margin_filt #(
  parameter int unsigned GLITCH_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic margin_n,
  output logic mon_off
);
  localparam int unsigned RUN_W = pwrgood_pkg::run_width(GLITCH_CYC);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(GLITCH_CYC - 1);

  logic             s1_q, s2_q;
  logic             filt_q;
  logic [RUN_W-1:0] run_q;
  logic             mismatch;

  // Two-flop synchronizer; resets to the floating-high level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= margin_n;
      s2_q <= s1_q;
    end
  end

  assign mismatch = (s2_q != filt_q);

  // Filtered level follows only after GLITCH_CYC consecutive mismatches.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b1;
      run_q  <= '0;
    end else if (!mismatch) begin
      run_q <= '0;
    end else if (run_q == RUN_LAST) begin
      filt_q <= s2_q;
      run_q  <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign mon_off = ~filt_q;

  // R9
  filt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt_q) |-> $past(s2_q));
  // R9
  filt_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(filt_q) |-> !$past(s2_q));
  // R10
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mismatch |=> $stable(filt_q));

endmodule

// File: rtl/pwrgood_rail_mon.sv
module pwrgood_rail_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic used,
  input  logic hi_rise,
  input  logic hi_fall,
  output logic good
);
  logic good_q;
  logic good_d;
  logic rail_lost;

  // Hysteresis latch: enter on the rising level, leave on the falling level.
  always_comb begin
    if (!used)       good_d = 1'b1;
    else if (good_q) good_d = hi_fall;
    else             good_d = hi_rise;
  end

  assign rail_lost = good_q & used & ~hi_fall & ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     good_q <= 1'b0;
    else if (!hold) good_q <= good_d;
  end

  assign good = good_q;

  // R3
  hyst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (good_q && used && hi_fall && !hold) |=> good_q);
  // R3
  hyst_lose_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rail_lost |=> !good_q);
  // R4
  unused_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!used && !hold) |=> good_q);
  // R8
  rail_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(good_q));

endmodule

// File: rtl/pwrgood_timer.sv
module pwrgood_timer #(
  parameter int unsigned BASE_CYC = 10000,
  parameter int unsigned UNIT_CYC = 5000,
  parameter int unsigned TSEL_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              qual,
  input  logic [TSEL_W-1:0] tmo_sel,
  output logic              pg
);
  localparam int unsigned CNT_W = pwrgood_pkg::pg_cnt_width(BASE_CYC, UNIT_CYC, TSEL_W);

  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_q;
  logic             pg_q;
  logic             expire;

  assign limit  = CNT_W'(pwrgood_pkg::pg_limit(BASE_CYC, UNIT_CYC, int'(tmo_sel)));
  assign expire = qual & ~pg_q & (cnt_q == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pg_q  <= 1'b0;
    end else if (!hold) begin
      if (!qual) begin
        cnt_q <= '0;
        pg_q  <= 1'b0;
      end else if (!pg_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (expire) pg_q <= 1'b1;
      end
    end
  end

  assign pg = pg_q;

  // R2
  rise_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_q) |-> $past(qual && !hold));
  // R5
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!qual && !hold) |=> (cnt_q == '0));
  // R6
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!qual && !hold) |=> !pg_q);
  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(pg_q) && $stable(cnt_q)));

endmodule

// File: rtl/pwrgood_reset.sv
module pwrgood_reset #(
  parameter int unsigned NRAIL      = 3,
  parameter int unsigned BASE_CYC   = 10000,
  parameter int unsigned UNIT_CYC   = 5000,
  parameter int unsigned TSEL_W     = 4,
  parameter int unsigned GLITCH_CYC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              margin_n,
  input  logic              en_ok,
  input  logic [NRAIL-1:0]  rail_uv_ok,
  input  logic [NRAIL-1:0]  rail_used,
  input  logic [NRAIL-1:0]  rail_hi_rise,
  input  logic [NRAIL-1:0]  rail_hi_fall,
  input  logic [TSEL_W-1:0] tmo_sel,
  output logic              pwr_good,
  output logic              mon_off
);
  logic             hold;
  logic [NRAIL-1:0] rail_good;
  logic             all_good;
  logic             supply_ok;
  logic             qual;

  pwrgood_margin_filt #(.GLITCH_CYC(GLITCH_CYC)) u_margin (
    .clk      (clk),
    .rst_n    (rst_n),
    .margin_n (margin_n),
    .mon_off  (hold)
  );

  for (genvar g = 0; g < NRAIL; g++) begin : g_rail
    pwrgood_rail_mon u_rail (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (hold),
      .used    (rail_used[g]),
      .hi_rise (rail_hi_rise[g]),
      .hi_fall (rail_hi_fall[g]),
      .good    (rail_good[g])
    );
  end

  assign all_good  = &rail_good;
  assign supply_ok = en_ok & (&rail_uv_ok);
  assign qual      = all_good & supply_ok;

  pwrgood_timer #(
    .BASE_CYC (BASE_CYC),
    .UNIT_CYC (UNIT_CYC),
    .TSEL_W   (TSEL_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (hold),
    .qual    (qual),
    .tmo_sel (tmo_sel),
    .pg      (pwr_good)
  );

  assign mon_off = hold;

  // R6
  supply_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!supply_ok && !mon_off) |=> !pwr_good);
  // R7
  rail_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_good && !mon_off) |=> !pwr_good);
  // R8
  top_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mon_off |=> $stable(pwr_good));

endmodule

// File: tb/pwrgood_reset_bench.sv
module pwrgood_reset_bench;
  localparam int NR = 3;
  localparam int BASE = 12;
  localparam int UNIT = 5;
  localparam int SW = 4;
  localparam int G = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic margin_n = 1'b1;
  logic en_ok = 1'b0;
  logic [NR-1:0] uv = '0, used = '1, rise = '0, fall = '0;
  logic [SW-1:0] sel = 4'd2;
  logic pwr_good, mon_off;

  typedef struct { string req; int pg; int mon; } item_t;
  item_t sb_q[$];
  event chk_ev;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwrgood_reset #(.NRAIL(NR), .BASE_CYC(BASE), .UNIT_CYC(UNIT),
                  .TSEL_W(SW), .GLITCH_CYC(G)) u_pwrgood_reset (
    .clk(clk), .rst_n(rst_n), .margin_n(margin_n), .en_ok(en_ok),
    .rail_uv_ok(uv), .rail_used(used), .rail_hi_rise(rise),
    .rail_hi_fall(fall), .tmo_sel(sel), .pwr_good(pwr_good), .mon_off(mon_off));

  function automatic int win(int s);
    return BASE + s * UNIT;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver side: queue an expectation (-1 = don't care).
  task automatic expect_now(string req, int pg, int mon);
    item_t it;
    it.req = req; it.pg = pg; it.mon = mon;
    sb_q.push_back(it);
    -> chk_ev;
  endtask

  task automatic drain();
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      if (it.pg >= 0) begin
        checks++;
        if (int'(pwr_good) != it.pg) begin
          fails++;
          $display("FAIL %s pwr_good actual=%0d expected=%0d", it.req, pwr_good, it.pg);
        end
      end
      if (it.mon >= 0) begin
        checks++;
        if (int'(mon_off) != it.mon) begin
          fails++;
          $display("FAIL %s mon_off actual=%0d expected=%0d", it.req, mon_off, it.mon);
        end
      end
    end
  endtask

  // Monitor side: compares queued expectations against the ports.
  initial forever begin
    @(chk_ev);
    drain();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int L, L0;
    L = win(2);
    L0 = win(0);
    tick(3);
    expect_now("R1", 0, 0);
    rst_n = 1'b1;
    tick(1);
    expect_now("R1", 0, 0);

    // R2: power-up with selection 2
    en_ok = 1'b1; uv = '1;
    tick(2);
    rise = '1; fall = '1;
    tick(L);   expect_now("R2", 0, 0);
    tick(1);   expect_now("R2", 1, 0);

    // R3: hysteresis keeps rail 1 good
    rise[1] = 1'b0;
    tick(5);   expect_now("R3", 1, -1);
    // R7: rail 0 lost
    rise[0] = 1'b0; fall[0] = 1'b0;
    tick(1);   expect_now("R7", 1, -1);
    tick(1);   expect_now("R7", 0, -1);

    // R5: restart on a mid-count loss
    rise[0] = 1'b1; fall[0] = 1'b1;
    tick(10);  expect_now("R5", 0, -1);
    rise[2] = 1'b0; fall[2] = 1'b0;
    tick(1);
    rise[2] = 1'b1; fall[2] = 1'b1;
    tick(L);   expect_now("R5", 0, -1);
    tick(1);   expect_now("R5", 1, -1);

    // R4: unused rail ignored
    used[2] = 1'b0; rise[2] = 1'b0; fall[2] = 1'b0;
    tick(6);   expect_now("R4", 1, -1);

    // R6: enable loss and return
    en_ok = 1'b0;
    tick(1);   expect_now("R6", 0, -1);
    en_ok = 1'b1;
    tick(L - 1); expect_now("R6", 0, -1);
    tick(1);   expect_now("R6", 1, -1);
    uv[1] = 1'b0;
    tick(1);   expect_now("R6", 0, -1);

    // R2: selection 0
    sel = '0; uv[1] = 1'b1;
    tick(L0 - 1); expect_now("R2", 0, -1);
    tick(1);   expect_now("R2", 1, -1);

    // R9: short margin pulse
    margin_n = 1'b0;
    tick(G - 1);
    margin_n = 1'b1;
    for (int i = 0; i < 2 * G + 4; i++) begin
      tick(1); expect_now("R9", 1, 0);
    end

    // R10: margin latency
    margin_n = 1'b0;
    tick(G + 1); expect_now("R10", 1, 0);
    tick(1);   expect_now("R10", 1, 1);

    // R8: frozen high while enable drops
    en_ok = 1'b0;
    tick(10);  expect_now("R8", 1, 1);
    margin_n = 1'b1;
    tick(G + 1); expect_now("R8", 1, 1);
    tick(1);   expect_now("R11", 1, 0);
    tick(1);   expect_now("R11", 0, 0);

    // R8: frozen low while enable returns
    margin_n = 1'b0;
    tick(G + 3); expect_now("R8", 0, 1);
    en_ok = 1'b1;
    tick(40);  expect_now("R8", 0, 1);
    margin_n = 1'b1;
    tick(G + 2); expect_now("R11", 0, 0);
    tick(L0 - 1); expect_now("R11", 0, 0);
    tick(1);   expect_now("R11", 1, 0);

    tick(2);
    drain();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule